// File: doc/BRIEF.md
# Clock Select Register Bank

This block is a memory-mapped register bank that holds the selection codes for a set of clock multiplexers. It stores one configuration word per entry. Software never writes a word directly. It changes bits through a write-one-to-set alias and a write-one-to-clear alias that sit next to each word. A new code only reaches a multiplexer when software writes a dedicated bit in one of the update strobe words. The multiplexer then takes the pending nibble, and keeps it until the next strobe.

A switch-over follows a fixed sequence. Software clears the whole nibble, then sets the new code, then writes the update bit. When the new code is zero, the set write is skipped. Two taps are brought out as active select outputs. Tap A is a 4-bit field at shift 0 of entry 22. Tap B is a 4-bit field at shift 16 of entry 28. Both reset to zero, which selects the reference clock. The bus is a single-cycle interface with byte addresses. Writes happen on the clock edge where the strobe is high. Read data is combinational.

Top module: `clksel_bank`

## Requirements
- R1: After reset, the mode word, every entry word, `sel_a` and `sel_b` are all zero. This holds also for a reset applied mid-run.
- R2: The mode word at byte address 0x000 stores any 32-bit write and reads it back.
- R3: A write to the set alias of entry n, at address 0x024 + 12·n, ORs the write data into the entry.
- R4: A write to the clear alias of entry n, at address 0x028 + 12·n, clears every entry bit that is one in the write data.
- R5: The current word of entry n, at address 0x020 + 12·n, reads the pending entry value. Writes to it have no effect.
- R6: These locations read as zero: the update words at 0x004, 0x008, 0x00C and 0x010 (update register k at 0x004 + 4·k); the reserved words 0x014 to 0x01C; every set and clear alias; and any address above 0x178.
- R7: A write to update register 2 (0x00C) with bit 24 set copies bits [3:0] of entry 22 into `sel_a`. The new value is visible from the clock edge that takes the write.
- R8: A write to update register 3 (0x010) with bit 18 set copies bits [19:16] of entry 28 into `sel_b`. The copy is the same when the pending code is zero, which is the clear-then-update path without a set write.
- R9: An update write without the tap's bit, or to a different update register, leaves that tap's select unchanged.
- R10: Changes to a pending entry do not reach `sel_a` or `sel_b` until the matching update bit is written.
- R11: A write whose address has bits [1:0] non-zero changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle while high |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| sel_a | output | 4 | Active select for tap A (entry 22, bits 3:0) |
| sel_b | output | 4 | Active select for tap B (entry 28, bits 19:16) |

## Verification
The bench checks that a pending code stays away from the output until its strobe. A design that wired the entry straight through would move `sel_a` as soon as the set write lands. It checks that an update word written without the right bit, or to the neighbouring register, does nothing. A decoder that matched on the register alone would latch there. It checks the zero-code path of clear followed by update, where a design that latched only on a set would leave the PLL code active. It checks unaligned writes and writes to the current word. A loose decoder would corrupt the entry on these. Reads of the strobes, the aliases and the reserved words must return zero, so a bank that echoed the last write would be caught.

// File: rtl/clksel_bank.sv
module clksel_bank #(
  parameter int NUM_ENTRIES  = 29,
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 9,
  parameter int SEL_W        = 4,
  parameter int NUM_UPD      = 4,
  parameter int NUM_RSVD     = 3,
  parameter int ENTRY_STRIDE = 12,
  parameter int A_ENTRY      = 22,
  parameter int A_SHIFT      = 0,
  parameter int A_UPD        = 2,
  parameter int A_BIT        = 24,
  parameter int B_ENTRY      = 28,
  parameter int B_SHIFT      = 16,
  parameter int B_UPD        = 3,
  parameter int B_BIT        = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [SEL_W-1:0]  sel_a,
  output logic [SEL_W-1:0]  sel_b
);
  localparam int ENTRY_BASE = 4 * (1 + NUM_UPD + NUM_RSVD);
  localparam logic [ADDR_W-1:0] MODE_ADDR  = '0;
  localparam logic [ADDR_W-1:0] UPD_A_ADDR = ADDR_W'(4 + 4 * A_UPD);
  localparam logic [ADDR_W-1:0] UPD_B_ADDR = ADDR_W'(4 + 4 * B_UPD);

  logic [DATA_W-1:0]      mode_q;
  logic [DATA_W-1:0]      ent [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] cur_hit;
  logic [SEL_W-1:0]       pend_a, pend_b;
  logic                   upd_a, upd_b;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mode_q <= '0;
    else if (bus_we && bus_addr == MODE_ADDR) mode_q <= bus_wdata;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    localparam logic [ADDR_W-1:0] CUR_ADDR = ADDR_W'(ENTRY_BASE + ENTRY_STRIDE * g);
    localparam logic [ADDR_W-1:0] SET_ADDR = ADDR_W'(ENTRY_BASE + ENTRY_STRIDE * g + 4);
    localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(ENTRY_BASE + ENTRY_STRIDE * g + 8);
    wire set_w = bus_we && bus_addr == SET_ADDR;
    wire clr_w = bus_we && bus_addr == CLR_ADDR;
    assign cur_hit[g] = bus_addr == CUR_ADDR;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)     ent[g] <= '0;
      else if (set_w) ent[g] <= ent[g] | bus_wdata;
      else if (clr_w) ent[g] <= ent[g] & ~bus_wdata;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == MODE_ADDR) bus_rdata = mode_q;
    for (int i = 0; i < NUM_ENTRIES; i++)
      if (cur_hit[i]) bus_rdata = ent[i];
  end

  assign pend_a = ent[A_ENTRY][A_SHIFT +: SEL_W];
  assign pend_b = ent[B_ENTRY][B_SHIFT +: SEL_W];
  assign upd_a  = bus_we && bus_addr == UPD_A_ADDR && bus_wdata[A_BIT];
  assign upd_b  = bus_we && bus_addr == UPD_B_ADDR && bus_wdata[B_BIT];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_a <= '0;
      sel_b <= '0;
    end else begin
      if (upd_a) sel_a <= pend_a;
      if (upd_b) sel_b <= pend_b;
    end
endmodule

// File: rtl/clksel_bank_chk.sv
module clksel_bank_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 9,
  parameter int SEL_W  = 4,
  parameter logic [ADDR_W-1:0] UPD_A_ADDR = 9'h00C,
  parameter logic [ADDR_W-1:0] UPD_B_ADDR = 9'h010,
  parameter logic [ADDR_W-1:0] CLR_A_ADDR = 9'h130,
  parameter int A_BIT   = 24,
  parameter int B_BIT   = 18,
  parameter int A_SHIFT = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [SEL_W-1:0]  sel_a,
  input logic [SEL_W-1:0]  sel_b,
  input logic [SEL_W-1:0]  pend_a,
  input logic [SEL_W-1:0]  pend_b
);
  wire strobe_a = bus_we && bus_addr == UPD_A_ADDR && bus_wdata[A_BIT];
  wire strobe_b = bus_we && bus_addr == UPD_B_ADDR && bus_wdata[B_BIT];
  wire upd_rd   = bus_addr >= ADDR_W'(4) && bus_addr <= ADDR_W'(16);

  a_r7_sel_a_latch: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_a |=> sel_a == $past(pend_a));
  a_r8_sel_b_latch: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_b |=> sel_b == $past(pend_b));
  a_r9_sel_a_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_a |=> $stable(sel_a));
  a_r9_sel_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_b |=> $stable(sel_b));
  a_r6_upd_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    upd_rd |-> bus_rdata == '0);
  a_r4_clear_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == CLR_A_ADDR && bus_wdata[A_SHIFT +: SEL_W] == '1) |=> pend_a == '0);
endmodule

bind clksel_bank clksel_bank_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W),
  .UPD_A_ADDR(UPD_A_ADDR), .UPD_B_ADDR(UPD_B_ADDR),
  .CLR_A_ADDR(ADDR_W'(ENTRY_BASE + ENTRY_STRIDE * A_ENTRY + 8)),
  .A_BIT(A_BIT), .B_BIT(B_BIT), .A_SHIFT(A_SHIFT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_rdata(bus_rdata), .sel_a(sel_a), .sel_b(sel_b),
  .pend_a(pend_a), .pend_b(pend_b)
);

// File: tb/tb_clksel_bank.sv
module tb_clksel_bank;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 0;
  logic [31:0] bus_rdata;
  logic [3:0]  sel_a, sel_b;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  clksel_bank dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
                   .bus_we(bus_we), .bus_rdata(bus_rdata), .sel_a(sel_a), .sel_b(sel_b));

  // {is_write, req, addr, data}: data is write data or expected read data
  localparam int NV = 16;
  localparam logic [45:0] VEC [NV] = '{
    {1'b0, 4'd1,  9'h000, 32'h0000_0000},  // R1 mode zero
    {1'b0, 4'd1,  9'h128, 32'h0000_0000},  // R1 entry zero
    {1'b1, 4'd2,  9'h000, 32'hA5A5_0001},
    {1'b0, 4'd2,  9'h000, 32'hA5A5_0001},  // R2
    {1'b1, 4'd3,  9'h024, 32'h0000_00F0},
    {1'b1, 4'd3,  9'h024, 32'h0000_0003},
    {1'b0, 4'd3,  9'h020, 32'h0000_00F3},  // R3
    {1'b1, 4'd4,  9'h028, 32'h0000_0031},
    {1'b0, 4'd4,  9'h020, 32'h0000_00C2},  // R4
    {1'b1, 4'd5,  9'h020, 32'hFFFF_FFFF},
    {1'b0, 4'd5,  9'h020, 32'h0000_00C2},  // R5
    {1'b0, 4'd6,  9'h024, 32'h0000_0000},  // R6 set alias
    {1'b0, 4'd6,  9'h014, 32'h0000_0000},  // R6 reserved
    {1'b1, 4'd11, 9'h021, 32'h0000_0001},
    {1'b1, 4'd11, 9'h026, 32'hFFFF_0000},
    {1'b0, 4'd11, 9'h020, 32'h0000_00C2}   // R11
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 sel_a", {28'd0, sel_a}, 32'd0);
    chk("R1 sel_b", {28'd0, sel_b}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][45]) wr(VEC[i][40:32], VEC[i][31:0]);
      else begin
        rd(VEC[i][40:32], r);
        chk($sformatf("R%0d vec%0d", VEC[i][44:41], i), r, VEC[i][31:0]);
      end
    end

    wr(9'h12C, 32'h0000_0008);
    rd(9'h128, r);          chk("R3 entry22", r, 32'h8);
    chk("R10 sel_a before update", {28'd0, sel_a}, 32'd0);
    wr(9'h00C, 32'h0100_0000);
    chk("R7 sel_a latched", {28'd0, sel_a}, 32'h8);
    rd(9'h00C, r);          chk("R6 update reads zero", r, 32'h0);
    wr(9'h130, 32'h0000_000F);
    wr(9'h12C, 32'h0000_0003);
    chk("R10 sel_a holds", {28'd0, sel_a}, 32'h8);
    wr(9'h008, 32'h0100_0000);
    chk("R9 other update reg", {28'd0, sel_a}, 32'h8);
    wr(9'h00C, 32'h00FF_FFFF);
    chk("R9 bit 24 clear", {28'd0, sel_a}, 32'h8);
    wr(9'h00C, 32'h0100_0000);
    chk("R7 second latch", {28'd0, sel_a}, 32'h3);

    wr(9'h174, 32'h0007_0000);
    chk("R10 sel_b before update", {28'd0, sel_b}, 32'h0);
    wr(9'h010, 32'h0004_0000);
    chk("R8 sel_b pll", {28'd0, sel_b}, 32'h7);
    wr(9'h178, 32'h000F_0000);
    wr(9'h010, 32'h0004_0000);
    chk("R8 sel_b zero path", {28'd0, sel_b}, 32'h0);
    chk("R9 sel_a untouched by update 3", {28'd0, sel_a}, 32'h3);
    rd(9'h17C, r);          chk("R6 beyond map", r, 32'h0);
    wr(9'h12D, 32'h0000_00FF);
    rd(9'h128, r);          chk("R11 unaligned", r, 32'h3);

    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk("R1 midrun sel_a", {28'd0, sel_a}, 32'h0);
    rst_n = 1;
    rd(9'h128, r);          chk("R1 midrun entry", r, 32'h0);
    rd(9'h000, r);          chk("R1 midrun mode", r, 32'h0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule